// File: doc/BRIEF.md
# Serial Configuration Frame Loader

The loader accepts a configuration bitstream one bit per clock, qualified by a valid strobe. It skips idle ones, reads a fixed-size header that carries a 24-bit length count, and then parses a parameterised number of equal-length frames. Each frame consists of a zero start bit, the frame payload, and a four-bit check field. After the last frame come eight postamble bits. The loader then consumes any remaining bits until the total count of accepted bits equals the length count.

Each frame's payload is run through a CRC-16 register using the 0x1021 polynomial. The low nibble of that register must match the frame's check field. When it matches, the payload is presented in parallel together with a one-cycle completion pulse. When it does not match, the loader drives its active-low init flag low and freezes until reset. The frame geometry comes from the array size: the payload width is 10·rows+21, and the frame count is 36·columns+68.

Top module: `cfg_frame_loader`

## Requirements
- R1: After reset, init_no is 1, frame_vld_o is 0 and done_o is 0.
- R2: Ones received before the first zero are skipped. That first zero is bit 0 of a 40-bit header. Header bits 4 to 27 carry the length count, most significant bit first.
- R3: Each frame is a zero start bit, then DATA_W payload bits, then 4 check bits. The first payload bit lands in frame_data_o's MSB. frame_vld_o is high for exactly the one cycle after the final check bit is accepted, and frame_data_o holds that frame's payload during that cycle.
- R4: The expected check field is bits [3:0] of a CRC-16 register, polynomial 0x1021, most significant bit first. The register is cleared at the start bit and fed each payload bit. Its bit 3 is the first check bit sent.
- R5: With crc_en_i=1, a check mismatch drives init_no low from the cycle after the last check bit. That frame gets no frame_vld_o pulse. init_no stays low until reset, and later bits produce neither frame_vld_o nor done_o.
- R6: With crc_en_i=0, the check bits have no effect on the result.
- R7: Ones that arrive after a frame's check bits and before the next start bit are skipped.
- R8: Eight postamble bits follow frame N_FRAMES-1. done_o rises the cycle after the bit that brings the total accepted bit count, leading ones included, to the length count. It then stays high.
- R9: Input bits presented while valid_i is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bit qualifier |
| bit_i | input | 1 | Serial stream bit |
| crc_en_i | input | 1 | Enables check-field comparison |
| frame_data_o | output | DATA_W | Payload of the latest frame |
| frame_vld_o | output | 1 | One-cycle frame completion pulse |
| done_o | output | 1 | Stream complete |
| init_no | output | 1 | Low after a check failure |

## Verification
The bench feeds whole streams with random valid gaps under four patterns. The first is clean frames with checking on, a few leading ones and a tail after the postamble; it confirms that header, frame and length parsing agree. The second has checking off, random ones between frames and a deliberately wrong check field; it separates gap skipping from check suppression. The third and fourth use a corrupted early frame with checking on, and a stream with no leading ones or tail. They show that the failure freezes the loader, and that done_o depends on the exact count and not on postamble detection alone.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  localparam int unsigned HDR_BITS  = 40;
  localparam int unsigned LEN_POS   = 4;
  localparam int unsigned CHK_BITS  = 4;
  localparam int unsigned POST_BITS = 8;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  typedef enum logic [3:0] {
    ST_LEAD, ST_HDR, ST_GAP, ST_DATA, ST_CHK, ST_POST, ST_TAIL, ST_DONE, ST_FAIL
  } ldr_state_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    crc_step = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/cfg_crc_unit.sv
module cfg_crc_unit
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             bit_i,
  output logic [OUT_W-1:0] crc_lo_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (upd_i) crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_lo_o = crc_q[OUT_W-1:0];
endmodule

// File: rtl/cfg_len_tracker.sv
module cfg_len_tracker #(
  parameter int unsigned LEN_W = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_en_i,
  input  logic cap_i,
  input  logic bit_i,
  output logic hit_o
);
  logic [LEN_W-1:0] len_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cap_i)    len_q <= {len_q[LEN_W-2:0], bit_i};
      if (cnt_en_i) cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  // true while the bit being accepted is the last one counted
  assign hit_o = (cnt_q + LEN_W'(1)) == len_q;
endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned DATA_W   = 121,
  parameter int unsigned N_FRAMES = 428,
  parameter int unsigned LEN_W    = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic              crc_en_i,
  input  logic [3:0]        crc_lo_i,
  input  logic              len_hit_i,
  output logic              crc_clr_o,
  output logic              crc_upd_o,
  output logic              cnt_en_o,
  output logic              hdr_cap_o,
  output logic [DATA_W-1:0] frame_data_o,
  output logic              frame_vld_o,
  output logic              done_o,
  output logic              init_no
);
  localparam int unsigned IDX_MAX = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
  localparam int unsigned IDX_W   = $clog2(IDX_MAX + 1);
  localparam int unsigned FRM_W   = $clog2(N_FRAMES + 1);

  ldr_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [FRM_W-1:0]  frm_q, frm_d;
  logic [2:0]        chk_q, chk_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;
  logic              chk_ok;

  assign chk_ok = !crc_en_i || ({chk_q, bit_i} == crc_lo_i);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    frm_d     = frm_q;
    chk_d     = chk_q;
    data_d    = data_q;
    vld_d     = 1'b0;
    crc_clr_o = 1'b0;
    crc_upd_o = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_LEAD: if (!bit_i) begin
          st_d  = ST_HDR;
          idx_d = IDX_W'(1);
        end
        ST_HDR: begin
          if (idx_q == IDX_W'(HDR_BITS - 1)) st_d = ST_GAP;
          idx_d = idx_q + IDX_W'(1);
        end
        ST_GAP: if (!bit_i) begin
          st_d      = ST_DATA;
          idx_d     = '0;
          crc_clr_o = 1'b1;
        end
        ST_DATA: begin
          data_d    = {data_q[DATA_W-2:0], bit_i};
          crc_upd_o = 1'b1;
          if (idx_q == IDX_W'(DATA_W - 1)) begin
            st_d  = ST_CHK;
            idx_d = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        ST_CHK: begin
          chk_d = {chk_q[1:0], bit_i};
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(CHK_BITS - 1)) begin
            idx_d = '0;
            if (!chk_ok) begin
              st_d = ST_FAIL;
            end else begin
              vld_d = 1'b1;
              frm_d = frm_q + FRM_W'(1);
              st_d  = (frm_q == FRM_W'(N_FRAMES - 1)) ? ST_POST : ST_GAP;
            end
          end
        end
        ST_POST: begin
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(POST_BITS - 1)) st_d = len_hit_i ? ST_DONE : ST_TAIL;
        end
        ST_TAIL: if (len_hit_i) st_d = ST_DONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LEAD;
      idx_q  <= '0;
      frm_q  <= '0;
      chk_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      frm_q  <= frm_d;
      chk_q  <= chk_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign cnt_en_o     = valid_i && (st_q != ST_DONE) && (st_q != ST_FAIL);
  assign hdr_cap_o    = valid_i && (st_q == ST_HDR) &&
                        (idx_q >= IDX_W'(LEN_POS)) && (idx_q < IDX_W'(LEN_POS + LEN_W));
  assign frame_data_o = data_q;
  assign frame_vld_o  = vld_q;
  assign done_o       = (st_q == ST_DONE);
  assign init_no      = (st_q != ST_FAIL);
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader #(
  parameter int unsigned N_ROWS = 10,
  parameter int unsigned N_COLS = 10,
  parameter int unsigned LEN_W  = 24,
  localparam int unsigned DATA_W   = 10 * N_ROWS + 7 + 13 + 1,
  localparam int unsigned N_FRAMES = 36 * N_COLS + 26 + 41 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic              crc_en_i,
  output logic [DATA_W-1:0] frame_data_o,
  output logic              frame_vld_o,
  output logic              done_o,
  output logic              init_no
);
  logic       crc_clr, crc_upd, cnt_en, hdr_cap, len_hit;
  logic [3:0] crc_lo;

  cfg_crc_unit #(.OUT_W(4)) i_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .upd_i(crc_upd), .bit_i, .crc_lo_o(crc_lo)
  );

  cfg_len_tracker #(.LEN_W(LEN_W)) i_len (
    .clk_i, .rst_ni, .cnt_en_i(cnt_en), .cap_i(hdr_cap), .bit_i, .hit_o(len_hit)
  );

  cfg_frame_fsm #(.DATA_W(DATA_W), .N_FRAMES(N_FRAMES), .LEN_W(LEN_W)) i_fsm (
    .clk_i, .rst_ni, .valid_i, .bit_i, .crc_en_i,
    .crc_lo_i(crc_lo), .len_hit_i(len_hit),
    .crc_clr_o(crc_clr), .crc_upd_o(crc_upd), .cnt_en_o(cnt_en), .hdr_cap_o(hdr_cap),
    .frame_data_o, .frame_vld_o, .done_o, .init_no
  );
endmodule

// File: rtl/cfg_frame_loader_chk.sv
module cfg_frame_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic frame_vld_o,
  input logic done_o,
  input logic init_no
);
  assert_vld_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o);
  assert_init_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_no |=> !init_no);
  assert_no_vld_in_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_no |-> !frame_vld_o);
  assert_no_done_in_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_no |-> !done_o);
  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_idle_no_vld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !frame_vld_o);
  assert_idle_no_fail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && init_no) |=> init_no);
endmodule

bind cfg_frame_loader cfg_frame_loader_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .frame_vld_o(frame_vld_o), .done_o(done_o), .init_no(init_no)
);

// File: tb/test_cfg_frame_loader.sv
module test_cfg_frame_loader;
  localparam int ROWS = 1;
  localparam int COLS = 1;
  localparam int DW   = 10 * ROWS + 21;
  localparam int NF   = 36 * COLS + 68;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          bit_i = 1'b1;
  logic          crc_en_i = 1'b1;
  logic [DW-1:0] frame_data_o;
  logic          frame_vld_o, done_o, init_no;

  int n_chk = 0;
  int n_fail = 0;

  cfg_frame_loader #(.N_ROWS(ROWS), .N_COLS(COLS), .LEN_W(24)) i_cfg_frame_loader (
    .clk_i, .rst_ni, .valid_i, .bit_i, .crc_en_i,
    .frame_data_o, .frame_vld_o, .done_o, .init_no
  );

  always #2 clk_i = ~clk_i;

  // stream and per-bit expected events
  bit            s_bit[$];
  int            s_frm[$];
  bit            s_done[$];
  bit            s_fail[$];
  logic [DW-1:0] fdata[NF];
  int            gap[NF];

  logic          exp_vld, exp_done, exp_init;
  int            exp_frm;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [DW-1:0] d);
    logic [15:0] c = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic push(bit b, int f, bit dn, bit fl);
    s_bit.push_back(b); s_frm.push_back(f); s_done.push_back(dn); s_fail.push_back(fl);
  endtask

  task automatic build(int lead, bit gaps, int bad, int tail, bit crc_on);
    int len;
    bit failed = 0;
    logic [63:0] r;
    logic [15:0] c;
    logic [3:0]  ck;
    s_bit.delete(); s_frm.delete(); s_done.delete(); s_fail.delete();
    len = lead + 40 + NF * (DW + 5) + 8 + tail;
    for (int f = 0; f < NF; f++) begin
      gap[f] = gaps ? int'($urandom % 4) : 0;
      len += gap[f];
      r = {$urandom, $urandom};
      fdata[f] = r[DW-1:0];
    end
    for (int i = 0; i < lead; i++) push(1, -1, 0, 0);
    // header: 0010, 24-bit length, 12 ones
    push(0, -1, 0, 0); push(0, -1, 0, 0); push(1, -1, 0, 0); push(0, -1, 0, 0);
    for (int i = 23; i >= 0; i--) push(len[i], -1, 0, 0);
    for (int i = 0; i < 12; i++) push(1, -1, 0, 0);
    for (int f = 0; f < NF; f++) begin
      push(0, -1, 0, 0);
      for (int i = DW - 1; i >= 0; i--) push(fdata[f][i], -1, 0, 0);
      c  = ref_crc(fdata[f]);
      ck = (f == bad) ? ~c[3:0] : c[3:0];
      for (int i = 3; i >= 1; i--) push(ck[i], -1, 0, 0);
      if (failed) push(ck[0], -1, 0, 0);
      else if (f == bad && crc_on) begin push(ck[0], -1, 0, 1); failed = 1; end
      else push(ck[0], f, 0, 0);
      for (int i = 0; i < gap[f]; i++) push(1, -1, 0, 0);
    end
    for (int i = 0; i < 8 + tail; i++) push(1, -1, 0, 0);
    if (!failed) s_done[s_done.size() - 1] = 1;
    for (int i = 0; i < 12; i++) push(i[0], -1, 0, 0);  // after end: must be ignored
  endtask

  task automatic compare();
    check(frame_vld_o == exp_vld, "R3 frame_vld_o", frame_vld_o, exp_vld);
    if (exp_vld && frame_vld_o)
      check(frame_data_o == fdata[exp_frm], "R3/R4 frame_data_o", frame_data_o, fdata[exp_frm]);
    check(done_o == exp_done, "R8 done_o", done_o, exp_done);
    check(init_no == exp_init, "R5 init_no", init_no, exp_init);
  endtask

  task automatic run(bit crc_on);
    int i = 0;
    crc_en_i = crc_on;
    exp_vld = 0; exp_done = 0; exp_init = 1; exp_frm = 0;
    while (i < s_bit.size()) begin
      @(negedge clk_i);
      compare();
      if ($urandom % 8 == 0) begin
        valid_i = 0; bit_i = $urandom % 2; exp_vld = 0;  // R9 idle cycle
      end else begin
        valid_i = 1; bit_i = s_bit[i];
        exp_vld = s_frm[i] >= 0;
        if (exp_vld) exp_frm = s_frm[i];
        if (s_done[i]) exp_done = 1;
        if (s_fail[i]) exp_init = 0;
        i++;
      end
    end
    repeat (3) begin
      @(negedge clk_i);
      compare();
      valid_i = 0; exp_vld = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; valid_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check(init_no == 1'b1, "R1 init_no", init_no, 1);
    check(frame_vld_o == 1'b0, "R1 frame_vld_o", frame_vld_o, 0);
    check(done_o == 1'b0, "R1 done_o", done_o, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R2 R8: leading ones and tail counted, checking on
    do_reset(); build(3, 0, -1, 5, 1); run(1);
    // R6 R7: checking off, gaps between frames, bad check field ignored
    do_reset(); build(7, 1, 5, 2, 0); run(0);
    // R5: corrupted frame 2 freezes the loader
    do_reset(); build(2, 0, 2, 0, 1); run(1);
    // R8: no leading ones, no tail
    do_reset(); build(0, 0, -1, 0, 1); run(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule